// File: doc/BRIEF.md
# Per-Row Countdown Refresh Tracker

This block decides which DRAM rows really need a refresh. It keeps a small down-counter for every row. A counter that reaches zero means the row has gone a full retention window without being opened. A normal read or write that opens a row already restores its charge, so such an access reloads that row's counter to the maximum. A row that is used often enough is therefore never refreshed explicitly.

The rows are cut into `SEGS` equal segments. An internal prescaler produces an update tick every `TICK_DIV` clock cycles. Each sweep step visits the same index in every segment at once. For each visited counter the block either decrements it or, if it is already zero, raises a refresh request for that row and reloads the counter. Counters start from staggered values, so the requests spread evenly over time and no step can produce more than `SEGS` of them.

A refresh engine downstream takes the requests as a per-segment valid vector with row addresses. It can hold off the sweep with a ready input while it is busy. Choosing `TICK_DIV` so that `(2**CW) * ROWS/SEGS` steps fit in one retention interval keeps every idle row inside its retention limit.

Top module: `row_refresh_tracker`

## Requirements
- R1: After reset every request valid bit is 0 and the sweep index is 0. The counter of the row at index i within its segment starts at MAX - (i mod (MAX+1)), where MAX = 2**CW-1. Row number = segment*RPS + index, with RPS = ROWS/SEGS.
- R2: An update tick occurs every TICK_DIV clock cycles. With ready high and no accesses after reset, the first requests appear on the 4*TICK_DIV-th cycle after reset is released (default parameters), one for each segment.
- R3: Each sweep step visits, in every segment s, the row s*RPS + index. The index then advances by one and wraps from RPS-1 to 0. The index does not change without a step.
- R4: A visited counter that is not zero is decremented and produces no request.
- R5: A visited counter that is zero sets req_valid[s]. It puts the row number in req_row bits [s*AW +: AW] and reloads the counter to MAX. The request is valid for exactly the one cycle after the step.
- R6: An access (acc_valid high) reloads the counter of acc_row to MAX. A row that is accessed continuously is never requested.
- R7: If an access and a sweep step hit the same row in the same cycle, the reload wins. The counter becomes MAX and no request is raised for that row.
- R8: While req_ready is low no step is taken. All ticks that arrive during the stall collapse into a single pending step, which runs on the first cycle with req_ready high.
- R9: Requests appear only in the cycle after a step, at most one per segment. The row in req_row slice s always lies in segment s.
- R10: With no accesses and ready held high, every row is requested exactly twice in the first 2*(MAX+1)*RPS steps after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | A normal access opens a row this cycle |
| acc_row | input | AW | Row opened by the access |
| req_ready | input | 1 | Downstream can take requests; low stalls the sweep |
| req_valid | output | SEGS | Per-segment refresh request valid, one-cycle pulse |
| req_row | output | SEGS*AW | Row address of each segment's request, slice s for segment s |

## Verification
The assertions check the following on every cycle:
- A stall blocks the step.
- Requests follow only a step.
- The sweep index steps and wraps, or holds still.
- Ticks never come back to back.
- A same-cycle access suppresses the request for the visited row.
- Each request slice carries a row of its own segment.

Whether the right rows come due at the right step depends on the staggered start values and on the counter history. Only the bench scenarios can show this, by comparing against a step-by-step reference model: the first due step after reset, the exact refresh count per row over two full sweeps, starvation of a row that is accessed continuously, the collapsing of ticks during a stall, and aimed collisions between access and sweep.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

  // Starting value of a counter at in-segment index idx: spreads due times.
  function automatic int unsigned stagger_init(int unsigned idx, int unsigned maxv);
    return maxv - (idx % (maxv + 1));
  endfunction

  // Global row number of index idx inside segment seg.
  function automatic int unsigned row_of(int unsigned seg, int unsigned idx, int unsigned rps);
    return seg * rps + idx;
  endfunction

  // Sweep index successor with wrap.
  function automatic int unsigned next_idx(int unsigned idx, int unsigned rps);
    return (idx + 1 >= rps) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/rrt_prescaler.sv
module rrt_prescaler #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] cnt;

  assign tick = (cnt == PW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rrt_sweep.sv
module rrt_sweep #(
  parameter int unsigned RPS = 16,
  parameter int unsigned IW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ready,
  output logic          step,
  output logic [IW-1:0] idx
);
  logic pend;
  logic want;

  assign want = pend | tick;
  assign step = want & ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      idx  <= '0;
    end else begin
      pend <= want & ~ready;
      if (step) idx <= IW'(rrt_pkg::next_idx(32'(idx), RPS));
    end
  end
endmodule

// File: rtl/rrt_segment.sv
module rrt_segment #(
  parameter int unsigned RPS = 16,
  parameter int unsigned IW  = 4,
  parameter int unsigned CW  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [IW-1:0] idx,
  input  logic          acc_hit,
  input  logic [IW-1:0] acc_idx,
  output logic          due
);
  localparam int unsigned    MAXV = (1 << CW) - 1;
  localparam logic [CW-1:0]  CMAX = CW'(MAXV);

  logic [CW-1:0] ctr [RPS];
  logic          collide;
  logic          is_zero;

  assign collide = acc_hit && (acc_idx == idx);
  assign is_zero = (ctr[idx] == '0);
  assign due     = step && is_zero && !collide;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(RPS); i++)
        ctr[i] <= CW'(rrt_pkg::stagger_init(32'(i), MAXV));
    end else begin
      if (step && !collide)
        ctr[idx] <= is_zero ? CMAX : ctr[idx] - 1'b1;
      if (acc_hit)
        ctr[acc_idx] <= CMAX;
    end
  end
endmodule

// File: rtl/row_refresh_tracker.sv
module row_refresh_tracker #(
  parameter int unsigned ROWS     = 64,
  parameter int unsigned SEGS     = 4,
  parameter int unsigned CW       = 2,
  parameter int unsigned TICK_DIV = 8,
  localparam int unsigned AW      = $clog2(ROWS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_valid,
  input  logic [AW-1:0]        acc_row,
  input  logic                 req_ready,
  output logic [SEGS-1:0]      req_valid,
  output logic [SEGS*AW-1:0]   req_row
);
  localparam int unsigned RPS = ROWS / SEGS;
  localparam int unsigned IW  = (RPS > 1) ? $clog2(RPS) : 1;

  logic          tick_w;
  logic          step_w;
  logic [IW-1:0] idx_w;
  logic [AW-1:0] acc_seg;
  logic [IW-1:0] acc_idx;
  logic [SEGS-1:0] due_w;

  assign acc_seg = acc_row / AW'(RPS);
  assign acc_idx = IW'(acc_row % AW'(RPS));

  rrt_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick(tick_w)
  );

  rrt_sweep #(.RPS(RPS), .IW(IW)) u_sweep (
    .clk(clk), .rst(rst), .tick(tick_w), .ready(req_ready),
    .step(step_w), .idx(idx_w)
  );

  for (genvar s = 0; s < int'(SEGS); s++) begin : g_seg
    logic          hit;
    logic [AW-1:0] row_q;

    assign hit = acc_valid && (acc_seg == AW'(s));

    rrt_segment #(.RPS(RPS), .IW(IW), .CW(CW)) u_bank (
      .clk(clk), .rst(rst), .step(step_w), .idx(idx_w),
      .acc_hit(hit), .acc_idx(acc_idx), .due(due_w[s])
    );

    always_ff @(posedge clk) begin
      if (rst)           row_q <= '0;
      else if (due_w[s]) row_q <= AW'(rrt_pkg::row_of(s, 32'(idx_w), RPS));
    end

    assign req_row[s*AW +: AW] = row_q;
  end

  always_ff @(posedge clk) begin
    if (rst) req_valid <= '0;
    else     req_valid <= due_w;
  end
endmodule

// File: rtl/rrt_checker.sv
module rrt_checker #(
  parameter int unsigned ROWS     = 64,
  parameter int unsigned SEGS     = 4,
  parameter int unsigned CW       = 2,
  parameter int unsigned TICK_DIV = 8,
  localparam int unsigned AW      = $clog2(ROWS),
  localparam int unsigned RPS     = ROWS / SEGS,
  localparam int unsigned IW      = (RPS > 1) ? $clog2(RPS) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               acc_valid,
  input logic [AW-1:0]      acc_row,
  input logic               req_ready,
  input logic [SEGS-1:0]    req_valid,
  input logic [SEGS*AW-1:0] req_row,
  input logic               tick,
  input logic               step,
  input logic [IW-1:0]      idx
);
  // R8
  stall_blocks_step_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> !step);

  // R9
  req_after_step_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> (req_valid == '0));

  // R3
  idx_advance_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (int'(idx) == ((int'($past(idx)) + 1) % int'(RPS))));

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(idx));

  if (TICK_DIV > 1) begin : g_tick
    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
  end

  for (genvar s = 0; s < int'(SEGS); s++) begin : g_s
    // R7
    reload_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (step && acc_valid && (int'(acc_row) == s * int'(RPS) + int'(idx)))
      |=> !req_valid[s]);

    // R9
    row_in_segment_chk: assert property (@(posedge clk) disable iff (rst)
      req_valid[s] |-> ((int'(req_row[s*AW +: AW]) / int'(RPS)) == s));
  end
endmodule

bind row_refresh_tracker rrt_checker #(
  .ROWS(ROWS), .SEGS(SEGS), .CW(CW), .TICK_DIV(TICK_DIV)
) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_row(acc_row),
  .req_ready(req_ready), .req_valid(req_valid), .req_row(req_row),
  .tick(tick_w), .step(step_w), .idx(idx_w)
);

// File: tb/tb_row_refresh_tracker.sv
`timescale 1ns/1ps
module tb_row_refresh_tracker;
  localparam int ROWS = 64;
  localparam int SEGS = 4;
  localparam int CW   = 2;
  localparam int DIV  = 8;
  localparam int RPS  = ROWS / SEGS;
  localparam int AW   = 6;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst;
  logic               acc_valid;
  logic [AW-1:0]      acc_row;
  logic               req_ready;
  logic [SEGS-1:0]    req_valid;
  logic [SEGS*AW-1:0] req_row;

  row_refresh_tracker #(.ROWS(ROWS), .SEGS(SEGS), .CW(CW), .TICK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_row(acc_row),
    .req_ready(req_ready), .req_valid(req_valid), .req_row(req_row)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    done = 1'b0;
  bit    cnt_en = 1'b0;
  int    refcnt [ROWS];

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Reference model, advanced at each rising edge from the requirements.
  int              m_pcnt, m_idx;
  bit              m_pend;
  int              m_ctr [ROWS];
  logic [SEGS-1:0] m_val;
  int              m_row [SEGS];

  always @(posedge clk) begin
    bit tk, fire;
    int r;
    if (rst) begin
      m_pcnt = 0; m_pend = 0; m_idx = 0; m_val = '0;
      for (int k = 0; k < ROWS; k++) m_ctr[k] = MAXV - ((k % RPS) % (MAXV + 1));
    end else begin
      tk     = (m_pcnt == DIV - 1);
      m_pcnt = tk ? 0 : m_pcnt + 1;
      fire   = (m_pend || tk) && req_ready;
      m_pend = (m_pend || tk) && !req_ready;
      m_val  = '0;
      if (fire) begin
        for (int s = 0; s < SEGS; s++) begin
          r = s * RPS + m_idx;
          if (acc_valid && int'(acc_row) == r) begin
          end else if (m_ctr[r] == 0) begin
            m_val[s] = 1'b1; m_row[s] = r; m_ctr[r] = MAXV;
          end else m_ctr[r] = m_ctr[r] - 1;
        end
        m_idx = (m_idx + 1) % RPS;
      end
      if (acc_valid) m_ctr[acc_row] = MAXV;
    end
  end

  // Compare outputs against the model away from the rising edge.
  always @(negedge clk) begin
    if (rst) chk(req_valid == '0, "R1", "req_valid in reset", req_valid, 0);
    else begin
      chk(req_valid == m_val, tag, "req_valid", req_valid, m_val);
      for (int s = 0; s < SEGS; s++) begin
        if (m_val[s] && req_valid[s])
          chk(int'(req_row[s*AW +: AW]) == m_row[s], tag, "req_row",
              req_row[s*AW +: AW], m_row[s]);
        if (cnt_en && req_valid[s]) refcnt[req_row[s*AW +: AW]]++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    int target;
    void'($urandom(32'd4242));
    rst = 1'b1; acc_valid = 1'b0; acc_row = '0; req_ready = 1'b1;
    for (int k = 0; k < ROWS; k++) refcnt[k] = 0;
    repeat (3) @(negedge clk);

    // R1 R2: staggered start, first requests on the 4*DIV-th cycle, all segments
    tag = "R1 R2 R4 R5";
    rst = 1'b0; cnt_en = 1'b1;
    n = 0;
    for (int c = 1; c <= 100; c++) begin
      @(negedge clk);
      n = c;
      if (req_valid != '0) break;
    end
    chk(n == 4 * DIV, "R2", "cycle of first request", n, 4 * DIV);
    chk(req_valid == 4'hF, "R1", "first request vector", req_valid, 15);

    // R10: two full sweep periods, every row refreshed exactly twice
    repeat (2 * (MAXV + 1) * RPS * DIV - n) @(negedge clk);
    for (int k = 0; k < ROWS; k++)
      chk(refcnt[k] == 2, "R10", "refreshes per row", refcnt[k], 2);

    // R8: stall across several ticks, then release
    tag = "R8";
    req_ready = 1'b0;
    for (int c = 0; c < 5 * DIV; c++) begin
      @(negedge clk);
      chk(req_valid == '0, "R8", "request during stall", req_valid, 0);
    end
    req_ready = 1'b1;
    repeat (4 * DIV) @(negedge clk);

    // R6: row 5 accessed every cycle is never requested
    tag = "R6";
    for (int k = 0; k < ROWS; k++) refcnt[k] = 0;
    acc_valid = 1'b1; acc_row = 6'd5;
    repeat (100 * DIV) @(negedge clk);
    chk(refcnt[5] == 0, "R6", "requests for accessed row", refcnt[5], 0);
    acc_valid = 1'b0;

    // R7: aim an access at a zero counter exactly on a step
    tag = "R7";
    for (int k = 0; k < 3; k++) begin
      for (int c = 0; c < 2000; c++) begin
        if (m_pcnt == DIV - 1 && !m_pend && m_ctr[k * RPS + m_idx] == 0) break;
        @(negedge clk);
      end
      target = k * RPS + m_idx;
      acc_valid = 1'b1; acc_row = AW'(target);
      @(negedge clk);
      acc_valid = 1'b0;
      chk(req_valid[k] == 1'b0, "R7", "request on collision", req_valid[k], 0);
      chk(m_ctr[target] == MAXV, "R7", "model reload on collision", m_ctr[target], MAXV);
      repeat (DIV) @(negedge clk);
    end

    // R3 R9: constrained random accesses and backpressure
    tag = "R3 R9";
    for (int c = 0; c < 4000; c++) begin
      acc_valid = ($urandom % 10) < 3;
      acc_row   = AW'($urandom % ROWS);
      req_ready = ($urandom % 10) < 9;
      @(negedge clk);
    end
    acc_valid = 1'b0; req_ready = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule